// File: doc/BRIEF.md
# Switching Regulator Soft-Start and Power-Good Sequencer

This block takes a multi-phase switching regulator from power-on reset to regulated operation. It counts switching cycles, one pulse of `cycleTick` per cycle. It steps the PWM outputs through three modes: high impedance, then clamped low, then active switching. While switching is active, it raises the error-amplifier reference code in a straight line from zero to the programmed target. The power-good flag stays low until a fixed cycle count is reached, even if the output has already settled.

Supply qualification comes from outside as two flags. `supplyUp` means the supply has crossed the upper power-on threshold. `supplyDown` means it has fallen below the lower threshold. The analog comparators and the reference converter are not part of this block. A restart request, for example after an overcurrent shutdown, runs the whole sequence again from the start of the high-impedance phase. Defaults: 32 high-impedance cycles, 150 clamped-low cycles, power-good from cycle 2048, 8-bit reference code. With these defaults the ramp is 1865 cycles long.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and at any time the sequencer is off, `pwmMode` is 0 (high impedance), `refCode` is 0 and `powerGood` is 0. Ticks have no effect until `supplyUp` is seen.
- R2: Once `supplyUp` has started the sequence, let n be the number of ticks counted since then. For n < 32, `pwmMode` is 0 and `refCode` is 0.
- R3: For 32 <= n < 182, `pwmMode` is 1 (driven low) and `refCode` is 0.
- R4: For n >= 182, `pwmMode` is 2 (active). For 182 <= n <= 2046, `refCode` equals floor(T*(n-181)/1865), where T is the target held at the start of the ramp. It never exceeds T, and it equals T at n = 2046.
- R5: With `cycleTick` low, the count, `pwmMode` and `refCode` do not change.
- R6: `powerGood` is 1 exactly when n has reached 2047 (the 2048th cycle), and it stays 1. From then on, `refCode` follows `targetCode` one clock after any change.
- R7: `supplyDown` returns the sequencer to the off state on the next clock. It takes priority over every other input.
- R8: `restartReq` while running restarts the sequence at n = 0 on the next clock, clearing `powerGood` and `refCode`. While off, it is ignored.
- R9: `targetCode` is captured on the tick that begins the ramp (n becomes 182). Changes during the ramp have no effect until R6 tracking begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycleTick | input | 1 | One-clock pulse per switching cycle |
| supplyUp | input | 1 | Supply above upper power-on threshold |
| supplyDown | input | 1 | Supply below lower power-on threshold |
| restartReq | input | 1 | Request to rerun the start-up sequence |
| targetCode | input | REF_W | Programmed reference target |
| refCode | output | REF_W | Reference code to the converter |
| pwmMode | output | 2 | 0 high impedance, 1 driven low, 2 active |
| powerGood | output | 1 | Power-good flag |

## Verification
The assertions assume that `cycleTick` is a one-clock strobe sampled on the rising edge. They also assume that the target is narrower than the ramp length, so that each tick adds at most one code step. The stimulus drives all inputs on the falling edge and raises `cycleTick` for whole clocks only. It uses targets of at most 255 against a ramp of 1865 cycles.

The supply flags and the restart request are single-clock pulses in the bench. Supply loss and restart are each applied both while running and while off.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [1:0] {
    PWM_TRI = 2'd0,
    PWM_LOW = 2'd1,
    PWM_RUN = 2'd2
  } pwm_mode_e;

  typedef enum logic {
    SEQ_OFF = 1'b0,
    SEQ_ON  = 1'b1
  } seq_state_e;

  // strobes from control to the reference datapath
  typedef struct packed {
    logic clr;    // zero reference and accumulator
    logic load;   // capture target at ramp start
    logic step;   // advance ramp by one cycle
    logic track;  // follow live target after ramp
  } ramp_strb_t;
endpackage

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import softstart_pkg::*;
#(
  parameter int TRI_CYC = 32,
  parameter int LOW_CYC = 150,
  parameter int PG_CYC  = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycleTick,
  input  logic       supplyUp,
  input  logic       supplyDown,
  input  logic       restartReq,
  output ramp_strb_t strb,
  output pwm_mode_e  pwmMode,
  output logic       powerGood
);
  localparam int CNT_W = $clog2(PG_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(PG_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_START  = CNT_W'(TRI_CYC);
  localparam logic [CNT_W-1:0] RAMP_FIRST = CNT_W'(TRI_CYC + LOW_CYC);
  localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(PG_CYC - 2);

  seq_state_e       state;
  logic [CNT_W-1:0] cycCnt;
  logic [CNT_W-1:0] cntNext;
  logic             running;
  logic             holdOn;
  logic             advance;

  assign running = (state == SEQ_ON);
  assign holdOn  = running && !supplyDown && !restartReq;
  assign cntNext = (cycCnt == CNT_MAX) ? cycCnt : cycCnt + 1'b1;
  assign advance = holdOn && cycleTick && (cycCnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_OFF;
      cycCnt <= '0;
    end else if (supplyDown) begin
      state  <= SEQ_OFF;
      cycCnt <= '0;
    end else if (!running) begin
      cycCnt <= '0;
      if (supplyUp) state <= SEQ_ON;
    end else if (restartReq) begin
      cycCnt <= '0;
    end else if (advance) begin
      cycCnt <= cntNext;
    end
  end

  always_comb begin
    strb.clr   = !running || supplyDown || restartReq;
    strb.load  = advance && (cntNext == RAMP_FIRST);
    strb.step  = advance && (cntNext >= RAMP_FIRST) && (cntNext <= RAMP_LAST);
    strb.track = holdOn && (cycCnt == CNT_MAX);
  end

  always_comb begin
    if (!running)               pwmMode = PWM_TRI;
    else if (cycCnt < LOW_START)  pwmMode = PWM_TRI;
    else if (cycCnt < RAMP_FIRST) pwmMode = PWM_LOW;
    else                          pwmMode = PWM_RUN;
  end

  assign powerGood = running && (cycCnt == CNT_MAX);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cycleTick && !supplyDown && !restartReq) |=> $stable(cycCnt));

  // R2
  tri_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && supplyUp && !supplyDown) |=> (pwmMode == PWM_TRI && !powerGood));

  // R3
  mode_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !supplyDown && !restartReq) |=> (pwmMode >= $past(pwmMode)));

  // R6
  pg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powerGood |-> (pwmMode == PWM_RUN));

  // R7
  down_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supplyDown |=> (pwmMode == PWM_TRI && !powerGood));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && restartReq) |=> (pwmMode == PWM_TRI && !powerGood));
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp
  import softstart_pkg::*;
#(
  parameter int REF_W    = 8,
  parameter int RAMP_LEN = 1865
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ramp_strb_t       strb,
  input  logic [REF_W-1:0] targetCode,
  output logic [REF_W-1:0] refCode
);
  localparam int ACC_W = $clog2(RAMP_LEN + (1 << REF_W) + 1);
  localparam logic [ACC_W-1:0] LEN_A = ACC_W'(RAMP_LEN);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accBase;
  logic [ACC_W-1:0] accSum;
  logic [REF_W-1:0] holdTgt;
  logic [REF_W-1:0] stepVal;
  logic [REF_W-1:0] refBase;
  logic [REF_W-1:0] refQ;
  logic             carry;

  always_comb begin
    accBase = strb.load ? '0 : acc;
    stepVal = strb.load ? targetCode : holdTgt;
    refBase = strb.load ? '0 : refQ;
    accSum  = accBase + ACC_W'(stepVal);
    carry   = (accSum >= LEN_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      holdTgt <= '0;
      refQ    <= '0;
    end else if (strb.clr) begin
      acc     <= '0;
      holdTgt <= '0;
      refQ    <= '0;
    end else if (strb.track) begin
      refQ <= targetCode;
    end else if (strb.step) begin
      if (strb.load) holdTgt <= targetCode;
      if (carry) begin
        acc  <= accSum - LEN_A;
        refQ <= refBase + 1'b1;
      end else begin
        acc  <= accSum;
        refQ <= refBase;
      end
    end
  end

  assign refCode = refQ;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> (refCode == '0));

  // R4
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.clr) |=> (refCode <= holdTgt));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.load && !strb.clr) |=>
      (refCode >= $past(refCode) && (refCode - $past(refCode)) <= 1));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int TRI_CYC = 32,
  parameter int LOW_CYC = 150,
  parameter int PG_CYC  = 2048,
  parameter int REF_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycleTick,
  input  logic             supplyUp,
  input  logic             supplyDown,
  input  logic             restartReq,
  input  logic [REF_W-1:0] targetCode,
  output logic [REF_W-1:0] refCode,
  output logic [1:0]       pwmMode,
  output logic             powerGood
);
  localparam int RAMP_LEN = PG_CYC - 1 - TRI_CYC - LOW_CYC;

  ramp_strb_t strb;
  pwm_mode_e  modeInt;

  ss_ctrl #(
    .TRI_CYC(TRI_CYC),
    .LOW_CYC(LOW_CYC),
    .PG_CYC (PG_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycleTick (cycleTick),
    .supplyUp  (supplyUp),
    .supplyDown(supplyDown),
    .restartReq(restartReq),
    .strb      (strb),
    .pwmMode   (modeInt),
    .powerGood (powerGood)
  );

  ss_ramp #(
    .REF_W   (REF_W),
    .RAMP_LEN(RAMP_LEN)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .targetCode(targetCode),
    .refCode   (refCode)
  );

  assign pwmMode = modeInt;
endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RAMP_LEN   = 1865;
  localparam int VEC_N      = 12;
  // {ticks since start, expected mode, expected power-good}
  localparam int VECS [VEC_N][3] = '{
    '{0, 0, 0}, '{5, 0, 0}, '{31, 0, 0}, '{32, 1, 0},
    '{100, 1, 0}, '{181, 1, 0}, '{182, 2, 0}, '{183, 2, 0},
    '{700, 2, 0}, '{1500, 2, 0}, '{2046, 2, 0}, '{2047, 2, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycleTick = 1'b0;
  logic       supplyUp = 1'b0;
  logic       supplyDown = 1'b0;
  logic       restartReq = 1'b0;
  logic [7:0] targetCode = 8'd0;
  logic [7:0] refCode;
  logic [1:0] pwmMode;
  logic       powerGood;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  softstart_seq u0 (
    .clk(clk), .rst_n(rst_n), .cycleTick(cycleTick), .supplyUp(supplyUp),
    .supplyDown(supplyDown), .restartReq(restartReq), .targetCode(targetCode),
    .refCode(refCode), .pwmMode(pwmMode), .powerGood(powerGood)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int refExp(int n, int t);
    if (n < 182) return 0;
    if (n >= 2046) return t;
    return (t * (n - 181)) / RAMP_LEN;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic advance(int n);
    for (int i = 0; i < n; i++) begin
      cycleTick = 1'b1;
      @(negedge clk);
    end
    cycleTick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseUp();
    supplyUp = 1'b1; @(negedge clk); supplyUp = 1'b0;
  endtask

  task automatic pulseDown();
    supplyDown = 1'b1; @(negedge clk); supplyDown = 1'b0;
  endtask

  task automatic pulseRestart();
    restartReq = 1'b1; @(negedge clk); restartReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int cur;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state, ticks ignored while off
    check("R1 mode", pwmMode, 0);
    check("R1 ref", refCode, 0);
    check("R1 pg", powerGood, 0);
    advance(40);
    check("R1 off ticks mode", pwmMode, 0);

    // vector walk, target 200
    targetCode = 8'd200;
    pulseUp();
    cur = 0;
    for (int v = 0; v < VEC_N; v++) begin
      advance(VECS[v][0] - cur);
      cur = VECS[v][0];
      check("R2/R3/R4 mode", pwmMode, VECS[v][1]);
      check("R4 ref", refCode, refExp(cur, 200));
      check("R6 pg", powerGood, VECS[v][2]);
    end
    // R6 holds and tracks target
    advance(50);
    check("R6 pg held", powerGood, 1);
    targetCode = 8'd50;
    idle(1);
    check("R6 track", refCode, 50);

    // R7 supply loss
    pulseDown();
    check("R7 mode", pwmMode, 0);
    check("R7 ref", refCode, 0);
    check("R7 pg", powerGood, 0);

    // R8 restart while running
    targetCode = 8'd255;
    pulseUp();
    advance(300);
    check("R8 pre ref", refCode, refExp(300, 255));
    // R5 no change without ticks
    idle(20);
    check("R5 ref", refCode, refExp(300, 255));
    check("R5 mode", pwmMode, 2);
    pulseRestart();
    check("R8 mode", pwmMode, 0);
    check("R8 ref", refCode, 0);
    advance(32);
    check("R8 low after restart", pwmMode, 1);
    // R8 restart while off is ignored
    pulseDown();
    pulseRestart();
    advance(40);
    check("R8 off ignored", pwmMode, 0);

    // R9 target captured at ramp start
    targetCode = 8'd100;
    pulseUp();
    advance(182);
    check("R9 first step", refCode, refExp(182, 100));
    targetCode = 8'd255;
    advance(1000 - 182);
    check("R9 mid", refCode, refExp(1000, 100));
    advance(2046 - 1000);
    check("R9 end", refCode, 100);
    advance(1);
    check("R9 pg", powerGood, 1);
    idle(1);
    check("R9 track after", refCode, 255);

    // R4 zero target stays at zero
    pulseDown();
    targetCode = 8'd0;
    pulseUp();
    advance(1200);
    check("R4 zero target", refCode, 0);
    check("R4 mode active", pwmMode, 2);

    finishRun();
  end
endmodule